// File: doc/BRIEF.md
# Expanded Data RAM Access Router

This block sits between a CPU's external-data-move request port and two possible targets: a small on-chip expanded data RAM and an off-chip multiplexed bus. Every request says whether it reads or writes and whether it uses an 8-bit register-indirect address or the 16-bit address held in one of two data pointers. A routing control input decides whether any request may be served on chip. Requests the RAM can hold stay inside and leave the off-chip pins alone. All other requests are driven out in three bus phases.

The request and response sides use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while an off-chip transfer is in flight or while a response is waiting. A response stays valid, with stable data, until the consumer raises `rsp_ready`. The pointer controls and the routing bit are plain level signals.

`RAM_BYTES` chooses 256 or 768 bytes of on-chip RAM.

Top module: `xram_router`

## Requirements
- R1: A request routed on chip raises `rsp_valid` in the first cycle after the accepting edge. A read returns the byte most recently written to that location.
- R2: While a request is served on chip, `bus_lo_oe` stays 0, `bus_wr_n` and `bus_rd_n` stay 1, and `bus_hi_out` keeps the value of `port_hi_hold`.
- R3: With `ext_sel`=1, every request goes off chip, including addresses the RAM holds.
- R4: A pointer request (`req_kind`=1) whose pointer value is at or above `RAM_BYTES` goes off chip. `bus_hi_out` carries pointer bits 15:8 and `bus_lo_out` carries bits 7:0 in the address phase.
- R5: With `RAM_BYTES`=768 and `ext_sel`=0, pointer addresses 0x100 to 0x2FF are served on chip. A register-indirect request (`req_kind`=0) reaches only 0x00 to 0xFF, through its 8-bit `req_addr8` field.
- R6: A register-indirect request that goes off chip puts `req_addr8` on `bus_lo_out` in the address phase. `bus_hi_out` keeps `port_hi_hold`.
- R7: An off-chip access takes three cycles after the accepting edge:
  - Address phase: the address is driven with `bus_lo_oe`=1 and both strobes at 1.
  - Strobe phase: `bus_wr_n`=0 with the write data driven, or `bus_rd_n`=0 with `bus_lo_oe`=0. A read samples `bus_lo_in` here.
  - Release phase: both strobes are at 1.
  
  `rsp_valid` rises in the fourth cycle.
- R8: Two 16-bit data pointers reset to 0, and the select reset value is 0. `ptr_load` writes the selected pointer, and `ptr_inc` adds one to it. `sel_toggle` flips the select, and the new pointer is used from the next cycle. `ptr_value` always shows the selected pointer.
- R9: `req_ready` is 0 while an off-chip access is in flight or `rsp_valid` is 1. A response held with `rsp_ready`=0 keeps `rsp_valid` and `rsp_rdata` stable.
- R10: `bus_wr_n` and `bus_rd_n` are never 0 in the same cycle. Each strobe is low for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_sel | input | 1 | 1 forces all requests off chip |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_kind | input | 1 | 0 register-indirect, 1 data pointer |
| req_addr8 | input | 8 | Register-indirect address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Access finished |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 8 | Read data (0 for writes) |
| ptr_load | input | 1 | Load selected pointer |
| ptr_load_val | input | 16 | Value to load |
| ptr_inc | input | 1 | Increment selected pointer |
| sel_toggle | input | 1 | Flip pointer select |
| ptr_sel | output | 1 | Current pointer select |
| ptr_value | output | 16 | Selected pointer value |
| port_hi_hold | input | 8 | Latched upper port register contents |
| bus_lo_out | output | 8 | Lower multiplexed address/data byte |
| bus_lo_oe | output | 1 | Lower byte output enable |
| bus_lo_in | input | 8 | Lower byte read data from the bus |
| bus_hi_out | output | 8 | Upper address byte |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |

## Verification
An on-chip result is due one cycle after the accepting edge. An off-chip result is due four cycles after it, and the address, strobe and release phases fall in cycles one to three. The bench drives inputs on the falling edge and counts falling edges from the accepting rising edge. It samples each phase's pins and the response in exactly the cycle the requirement names. A latency other than the expected count is reported as a failure. Back-pressure is checked by holding `rsp_ready` low across several cycles and comparing the response and `req_ready` each cycle.

// File: rtl/xr_pkg.sv
package xr_pkg;
  typedef enum logic {KIND_REG = 1'b0, KIND_PTR = 1'b1} xr_kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_STRB, PH_REL} xr_phase_e;
endpackage

// File: rtl/xr_dptr_bank.sv
module xr_dptr_bank #(
  parameter int PTR_W = 16,
  parameter int N_PTR = 2,
  localparam int SEL_W = (N_PTR > 1) ? $clog2(N_PTR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  input  logic             sel_step,
  output logic [SEL_W-1:0] sel,
  output logic [PTR_W-1:0] cur
);
  logic [PTR_W-1:0] ptrs [N_PTR];

  // Each pointer only moves while it is the selected one.
  for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptrs[i] <= '0;
      end else if (sel == SEL_W'(i)) begin
        if (load)     ptrs[i] <= load_val;
        else if (inc) ptrs[i] <= ptrs[i] + 1'b1;
      end
    end
  end

  // The select register steps by one and wraps, which toggles it when N_PTR is 2.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
    end else if (sel_step) begin
      if (sel == SEL_W'(N_PTR - 1)) sel <= '0;
      else                          sel <= sel + 1'b1;
    end
  end

  assign cur = ptrs[sel];
endmodule

// File: rtl/xr_route_dec.sv
module xr_route_dec #(
  parameter int RAM_BYTES = 768
) (
  input  logic        ext_sel,
  input  logic        use_ptr,
  input  logic [15:0] ptr_addr,
  input  logic [7:0]  reg_addr,
  output logic        to_ram,
  output logic [15:0] eff_addr
);
  localparam logic [16:0] LIMIT = 17'(RAM_BYTES);
  localparam bit REG_FITS = (RAM_BYTES >= 256);

  always_comb begin
    eff_addr = use_ptr ? ptr_addr : {8'h00, reg_addr};
    if (ext_sel)      to_ram = 1'b0;
    else if (use_ptr) to_ram = ({1'b0, ptr_addr} < LIMIT);
    else              to_ram = REG_FITS;
  end
endmodule

// File: rtl/xr_ram.sv
module xr_ram #(
  parameter int DEPTH  = 768,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/xr_ext_seq.sv
module xr_ext_seq
  import xr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        write,
  input  logic        use_ptr,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic [7:0]  hi_hold,
  input  logic [7:0]  lo_in,
  output logic [7:0]  lo_out,
  output logic        lo_oe,
  output logic [7:0]  hi_out,
  output logic        wr_n,
  output logic        rd_n,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdata
);
  xr_phase_e   phase;
  logic        l_write;
  logic        l_ptr;
  logic [15:0] l_addr;
  logic [7:0]  l_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      l_write <= 1'b0;
      l_ptr   <= 1'b0;
      l_addr  <= '0;
      l_wdata <= '0;
      rdata   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_ADDR;
          l_write <= write;
          l_ptr   <= use_ptr;
          l_addr  <= addr;
          l_wdata <= wdata;
        end
        PH_ADDR: phase <= PH_STRB;
        PH_STRB: begin
          phase <= PH_REL;
          if (!l_write) rdata <= lo_in;
        end
        PH_REL:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy   = (phase != PH_IDLE);
    done   = (phase == PH_REL);
    hi_out = (busy && l_ptr) ? l_addr[15:8] : hi_hold;
    lo_out = 8'h00;
    lo_oe  = 1'b0;
    wr_n   = 1'b1;
    rd_n   = 1'b1;
    if (phase == PH_ADDR) begin
      lo_out = l_addr[7:0];
      lo_oe  = 1'b1;
    end else if (phase == PH_STRB) begin
      if (l_write) begin
        lo_out = l_wdata;
        lo_oe  = 1'b1;
        wr_n   = 1'b0;
      end else begin
        rd_n   = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xram_router.sv
module xram_router
  import xr_pkg::*;
#(
  parameter int RAM_BYTES = 768,
  parameter int N_PTR     = 2,
  localparam int AW    = $clog2(RAM_BYTES),
  localparam int SEL_W = (N_PTR > 1) ? $clog2(N_PTR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_kind,
  input  logic [7:0]       req_addr8,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_rdata,
  input  logic             ptr_load,
  input  logic [15:0]      ptr_load_val,
  input  logic             ptr_inc,
  input  logic             sel_toggle,
  output logic [SEL_W-1:0] ptr_sel,
  output logic [15:0]      ptr_value,
  input  logic [7:0]       port_hi_hold,
  output logic [7:0]       bus_lo_out,
  output logic             bus_lo_oe,
  input  logic [7:0]       bus_lo_in,
  output logic [7:0]       bus_hi_out,
  output logic             bus_wr_n,
  output logic             bus_rd_n
);
  logic        acc, to_ram, use_ptr;
  logic [15:0] eff_addr;
  logic [7:0]  ram_q, ext_q;
  logic        ext_busy, ext_done;
  logic        src_ram, was_rd;

  assign use_ptr = (req_kind == KIND_PTR);

  xr_dptr_bank #(.PTR_W(16), .N_PTR(N_PTR)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .sel_step(sel_toggle), .sel(ptr_sel), .cur(ptr_value)
  );

  xr_route_dec #(.RAM_BYTES(RAM_BYTES)) u_dec (
    .ext_sel(ext_sel), .use_ptr(use_ptr), .ptr_addr(ptr_value),
    .reg_addr(req_addr8), .to_ram(to_ram), .eff_addr(eff_addr)
  );

  assign req_ready = !rsp_valid && !ext_busy;
  assign acc       = req_valid && req_ready;

  xr_ram #(.DEPTH(RAM_BYTES), .DATA_W(8)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(acc && to_ram && req_write), .re(acc && to_ram && !req_write),
    .addr(eff_addr[AW-1:0]), .wdata(req_wdata), .rdata(ram_q)
  );

  xr_ext_seq u_ext (
    .clk(clk), .rst_n(rst_n), .start(acc && !to_ram), .write(req_write),
    .use_ptr(use_ptr), .addr(eff_addr), .wdata(req_wdata),
    .hi_hold(port_hi_hold), .lo_in(bus_lo_in), .lo_out(bus_lo_out),
    .lo_oe(bus_lo_oe), .hi_out(bus_hi_out), .wr_n(bus_wr_n), .rd_n(bus_rd_n),
    .busy(ext_busy), .done(ext_done), .rdata(ext_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_ram   <= 1'b0;
      was_rd    <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (acc) begin
        was_rd  <= !req_write;
        src_ram <= to_ram;
      end
      if ((acc && to_ram) || ext_done) rsp_valid <= 1'b1;
    end
  end

  assign rsp_rdata = !was_rd ? 8'h00 : (src_ram ? ram_q : ext_q);
endmodule

// File: rtl/xram_router_chk.sv
module xram_router_chk #(
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_sel,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_kind,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_rdata,
  input logic             sel_toggle,
  input logic [SEL_W-1:0] ptr_sel,
  input logic             bus_lo_oe,
  input logic             bus_wr_n,
  input logic             bus_rd_n
);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_wr_n && !bus_rd_n));
  p_wr_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |=> bus_wr_n);
  p_rd_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |=> bus_rd_n);
  p_read_floats_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_lo_oe);
  p_wr_after_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $past(bus_lo_oe) && $past(bus_rd_n));
  p_rd_after_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |-> $past(bus_lo_oe) && $past(bus_wr_n));
  p_ram_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ext_sel && !req_kind)
      |=> bus_wr_n && bus_rd_n && !bus_lo_oe);
  p_ram_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ext_sel && !req_kind) |=> rsp_valid);
  p_hold_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));
  p_ready_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  p_sel_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_toggle |=> ptr_sel != $past(ptr_sel));
endmodule

bind xram_router xram_router_chk #(.SEL_W(SEL_W)) chk_i (.*);

// File: tb/xram_router_tb_top.sv
module xram_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ext_sel = 0, req_valid = 0, req_write = 0, req_kind = 0;
  logic [7:0] req_addr8 = 0, req_wdata = 0, bus_lo_in = 0;
  logic rsp_ready = 1, ptr_load = 0, ptr_inc = 0, sel_toggle = 0;
  logic [15:0] ptr_load_val = 0;
  logic [7:0] port_hi_hold = 8'hA5;
  logic req_ready, rsp_valid, bus_lo_oe, bus_wr_n, bus_rd_n;
  logic [7:0] rsp_rdata, bus_lo_out, bus_hi_out;
  logic [0:0] ptr_sel;
  logic [15:0] ptr_value;

  int n_run = 0, n_fail = 0;

  xram_router dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request; returns rdata and the latency in cycles after acceptance.
  // When quiet_chk is set, every cycle before the response checks idle bus pins (R2).
  // When ext_chk is set, the three bus phases are checked (R7) against exp_* values.
  task automatic access(input bit wr, input bit kind, input logic [7:0] a8,
                        input logic [7:0] wd, input bit quiet_chk, input bit ext_chk,
                        input logic [7:0] exp_lo, input logic [7:0] exp_hi,
                        output logic [7:0] rd, output int lat);
    @(negedge clk);
    req_write = wr; req_kind = kind; req_addr8 = a8; req_wdata = wd; req_valid = 1;
    @(posedge clk); #1 req_valid = 0;
    lat = 0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      lat = c;
      if (quiet_chk) begin
        chk(bus_wr_n && bus_rd_n && !bus_lo_oe, "R2 strobes/oe idle",
            {bus_wr_n, bus_rd_n, bus_lo_oe}, 3'b110);
        chk(bus_hi_out == port_hi_hold, "R2 upper port kept", bus_hi_out, port_hi_hold);
      end
      if (ext_chk && c == 1) begin
        chk(bus_lo_oe && bus_wr_n && bus_rd_n && bus_lo_out == exp_lo,
            "R7 address phase lo", bus_lo_out, exp_lo);
        chk(bus_hi_out == exp_hi, "R4/R6 address phase hi", bus_hi_out, exp_hi);
      end
      if (ext_chk && c == 2) begin
        if (wr) chk(!bus_wr_n && bus_rd_n && bus_lo_oe && bus_lo_out == wd,
                    "R7 write strobe phase", {bus_wr_n, bus_rd_n, bus_lo_out}, {2'b01, wd});
        else    chk(!bus_rd_n && bus_wr_n && !bus_lo_oe,
                    "R7 read strobe phase", {bus_wr_n, bus_rd_n, bus_lo_oe}, 3'b100);
      end
      if (ext_chk && c == 3)
        chk(bus_wr_n && bus_rd_n, "R7/R10 release phase", {bus_wr_n, bus_rd_n}, 2'b11);
      if (rsp_valid) break;
    end
    rd = rsp_rdata;
  endtask

  task automatic t_reset;
    chk(req_ready && !rsp_valid, "R9 reset handshake", {req_ready, rsp_valid}, 2'b10);
    chk(bus_wr_n && bus_rd_n && !bus_lo_oe, "R10 reset strobes",
        {bus_wr_n, bus_rd_n, bus_lo_oe}, 3'b110);
    chk(ptr_sel == 0 && ptr_value == 0, "R8 reset pointers", ptr_value, 0);
  endtask

  task automatic ptr_op(input bit ld, input logic [15:0] v, input bit inc, input bit tg);
    @(negedge clk);
    ptr_load = ld; ptr_load_val = v; ptr_inc = inc; sel_toggle = tg;
    @(negedge clk);
    ptr_load = 0; ptr_inc = 0; sel_toggle = 0;
  endtask

  task automatic t_ram_reg;
    logic [7:0] rd; int lat;
    access(1, 0, 8'h3C, 8'h5A, 1, 0, 0, 0, rd, lat);
    chk(lat == 1, "R1 write latency", lat, 1);
    access(1, 0, 8'hF0, 8'h11, 1, 0, 0, 0, rd, lat);
    access(0, 0, 8'h3C, 8'h00, 1, 0, 0, 0, rd, lat);
    chk(lat == 1, "R1 read latency", lat, 1);
    chk(rd == 8'h5A, "R1 read data", rd, 8'h5A);
  endtask

  task automatic t_pointers;
    ptr_op(1, 16'h0123, 0, 0);
    chk(ptr_value == 16'h0123, "R8 load ptr0", ptr_value, 16'h0123);
    ptr_op(0, 0, 0, 1);
    chk(ptr_sel == 1 && ptr_value == 16'h0000, "R8 toggle to ptr1", ptr_value, 0);
    ptr_op(1, 16'h02F0, 0, 0);
    ptr_op(0, 0, 0, 1);
    chk(ptr_sel == 0 && ptr_value == 16'h0123, "R8 toggle back", ptr_value, 16'h0123);
    ptr_op(0, 0, 1, 0);
    chk(ptr_value == 16'h0124, "R8 increment", ptr_value, 16'h0124);
    ptr_op(0, 0, 0, 1);
    chk(ptr_value == 16'h02F0, "R8 ptr1 kept", ptr_value, 16'h02F0);
  endtask

  task automatic t_large_range;
    logic [7:0] rd; int lat;
    access(1, 1, 8'h00, 8'hC3, 1, 0, 0, 0, rd, lat);
    chk(lat == 1, "R5 pointer 0x2F0 on chip", lat, 1);
    access(0, 0, 8'hF0, 8'h00, 1, 0, 0, 0, rd, lat);
    chk(rd == 8'h11, "R5 reg 0xF0 separate from 0x2F0", rd, 8'h11);
    access(0, 1, 8'h00, 8'h00, 1, 0, 0, 0, rd, lat);
    chk(rd == 8'hC3, "R5 pointer 0x2F0 read", rd, 8'hC3);
  endtask

  task automatic t_ptr_external;
    logic [7:0] rd; int lat;
    ptr_op(1, 16'h0300, 0, 0);
    access(1, 1, 8'h00, 8'h77, 0, 1, 8'h00, 8'h03, rd, lat);
    chk(lat == 4, "R4 write 0x300 off chip latency", lat, 4);
    ptr_op(1, 16'h1234, 0, 0);
    bus_lo_in = 8'h9E;
    access(0, 1, 8'h00, 8'h00, 0, 1, 8'h34, 8'h12, rd, lat);
    chk(lat == 4, "R7 read latency", lat, 4);
    chk(rd == 8'h9E, "R7 read data sampled", rd, 8'h9E);
  endtask

  task automatic t_force_external;
    logic [7:0] rd; int lat;
    ext_sel = 1; bus_lo_in = 8'h42;
    access(0, 0, 8'h3C, 8'h00, 0, 1, 8'h3C, 8'hA5, rd, lat);
    chk(lat == 4 && rd == 8'h42, "R3/R6 reg read forced off chip", rd, 8'h42);
    ptr_op(1, 16'h0005, 0, 0);
    access(1, 1, 8'h00, 8'hE1, 0, 1, 8'h05, 8'h00, rd, lat);
    chk(lat == 4, "R3 pointer 0x005 forced off chip", lat, 4);
    ext_sel = 0;
    access(0, 0, 8'h3C, 8'h00, 1, 0, 0, 0, rd, lat);
    chk(rd == 8'h5A, "R3 off-chip accesses left RAM alone", rd, 8'h5A);
  endtask

  task automatic t_backpressure;
    logic [7:0] rd; int lat;
    rsp_ready = 0;
    access(0, 0, 8'h3C, 8'h00, 1, 0, 0, 0, rd, lat);
    req_valid = 1; req_write = 1; req_addr8 = 8'h3C; req_wdata = 8'hFF;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == 8'h5A && !req_ready, "R9 response held",
          {rsp_valid, req_ready, rsp_rdata}, {2'b10, 8'h5A});
    end
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 response released", {rsp_valid, req_ready}, 2'b01);
    access(0, 0, 8'h3C, 8'h00, 1, 0, 0, 0, rd, lat);
    chk(rd == 8'h5A, "R9 blocked request had no effect", rd, 8'h5A);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ram_reg();
    t_pointers();
    t_large_range();
    t_ptr_external();
    t_force_external();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule